// File: doc/BRIEF.md
# Timestamped Sample Logging Arbiter

This block merges four producer channels into one stream of 16-bit log words. The words are grouped in fixed-size samples. Each producer signals an event with a one-cycle timestamp request pulse. The arbiter holds that pulse as a level toward a shared timestamp store until the store grants it. After the grant, a channel that is also ready may take part in arbitration. Channels are served round-robin.

A served channel gets one sample of 32 word slots, one slot per clock cycle. The first four slots carry timestamp words, which the store supplies when given the channel number and a word select. The other 28 slots carry channel data. Each data word is pulled from the channel with a next strobe. When the channel's ready drops partway through a sample, the remaining data slots are filled with zeros, so every sample has the same length. The words pass through a two-stage registered multiplexer. A valid strobe marks each word at the output. A 24-bit counter counts finished samples.

The output stream has no back-pressure. Each valid word must be taken in the cycle it is presented. A producer must hold its word on the data input while it is ready, and it advances to the next word on each next strobe. The timestamp store must present the requested word on the timestamp input one cycle after the channel number and word select are shown.

Top module: `sample_log_arbiter`

## Requirements
- R1: While reset is asserted and after its release, all of the following are zero until the first request arrives: the held requests, the next strobes, the timestamp/data select, the valid strobe and the sample counter.
- R2: A pulse on `ts_req_pulse[i]` makes `ts_req_hold[i]` high from the next cycle on. It stays high until a cycle in which `ts_grant[i]` is high, and it is low in the cycle after that grant unless a new pulse arrived in the grant cycle.
- R3: A grant counts for channel i only if `ts_req_hold[i]` is high in the grant cycle. A grant with no held request has no effect. A channel starts a sample only when the arbiter is idle, the channel holds such a grant that no sample has yet used, and `chan_ready[i]` is high.
- R4: Among the eligible channels, the first one after the last served channel in the ascending order 0,1,2,3,0,… wins. After reset the search starts at channel 0.
- R5: A sample occupies 32 consecutive slot cycles, and `sel_chan` shows the served channel throughout. In slots 0 to 3 `ts_word_sel` equals the slot number, and in slots 4 to 31 it is 0. There is at least one idle cycle between samples.
- R6: In data slots (4 to 31), `chan_next` has only bit `sel_chan` set, and only when that channel's ready is high in the same cycle. In timestamp slots and in idle cycles `chan_next` is zero.
- R7: `ts_select` is 1 in the cycle after each timestamp slot. It is 0 in the cycle after each data slot or idle cycle.
- R8: `word_valid` is high exactly two cycles after each slot cycle, which gives 32 valid words per sample.
- R9: A valid word after a timestamp slot equals `ts_data` as it was one cycle after that slot. A valid word after a data slot equals the served channel's `chan_data` field (bits 16*ch+15 to 16*ch) as it was in the slot cycle if the channel was ready then, and is zero otherwise.
- R10: `sample_count` increments by one in the cycle after slot 31 of each sample and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ts_req_pulse | input | 4 | One-cycle timestamp request per channel |
| ts_grant | input | 4 | Timestamp stored, per channel |
| ts_req_hold | output | 4 | Stretched requests toward the timestamp store |
| chan_ready | input | 4 | Channel has data (level) |
| chan_data | input | 64 | Current data word of each channel, 16 bits per channel |
| chan_next | output | 4 | Per-channel strobe to advance to the next word |
| ts_data | input | 16 | Timestamp word from the store |
| sel_chan | output | 2 | Channel being served |
| ts_word_sel | output | 2 | Timestamp word index for the store |
| ts_select | output | 1 | Second mux stage takes the timestamp word |
| log_word | output | 16 | Output word |
| word_valid | output | 1 | Output word valid |
| sample_count | output | 24 | Number of finished samples |

## Verification
The assertions check the following on every cycle:
- a held request survives until its grant, and a grant clears it;
- the round-robin pick is one-hot and only picks eligible channels;
- the channel number stays stable within a sample;
- the next strobes are one-hot and never fall in timestamp slots;
- a zero-filled slot outputs zero;
- the sample counter only ever steps by one.

Only the bench's scenarios can show the following:
- the actual service order across channels;
- that an unrequested grant is ignored;
- the word-for-word content and zero padding after a mid-sample ready drop;
- the exact 32-word sample framing against a cycle model.

// File: rtl/slog_pkg.sv
package slog_pkg;
  localparam int DEF_NUM_CH       = 4;
  localparam int DEF_WORD_W       = 16;
  localparam int DEF_TS_WORDS     = 4;
  localparam int DEF_SAMPLE_WORDS = 32;
  localparam int DEF_CNT_W        = 24;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/slog_req_hold.sv
module slog_req_hold #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_pulse,
  input  logic [NUM_CH-1:0] grant,
  input  logic [NUM_CH-1:0] consume,
  output logic [NUM_CH-1:0] hold_o,
  output logic [NUM_CH-1:0] stamped_o
);
  logic [NUM_CH-1:0] hold_q;
  logic [NUM_CH-1:0] stamped_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      stamped_q <= '0;
    end else begin
      hold_q    <= (hold_q & ~grant) | req_pulse;
      stamped_q <= (stamped_q & ~consume) | (grant & hold_q);
    end
  end

  assign hold_o    = hold_q;
  assign stamped_o = stamped_q;

  // R2: an ungranted held request is still held next cycle
  assert_hold_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hold_q & ~grant)) |=> ((hold_q & $past(hold_q & ~grant)) == $past(hold_q & ~grant)));

  // R2: a grant without a fresh pulse drops the held request
  assert_grant_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & ~req_pulse)) |=> ((hold_q & $past(grant & ~req_pulse)) == '0));
endmodule

// File: rtl/slog_rr_pick.sv
module slog_rr_pick #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] elig,
  input  logic              take,
  output logic [NUM_CH-1:0] pick,
  output logic              pick_any,
  output logic [CH_W-1:0]   pick_idx
);
  logic [CH_W-1:0] last_q;

  always_comb begin
    int c;
    pick     = '0;
    pick_any = 1'b0;
    pick_idx = last_q;
    c        = 0;
    for (int k = 1; k <= NUM_CH; k++) begin
      c = (int'(last_q) + k) % NUM_CH;
      if (!pick_any && elig[c]) begin
        pick_any = 1'b1;
        pick[c]  = 1'b1;
        pick_idx = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= CH_W'(NUM_CH - 1);
    else if (take) last_q <= pick_idx;
  end

  // R4: at most one channel wins
  assert_pick_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  // R3: the winner is always an eligible channel
  assert_pick_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick & ~elig) == '0));
endmodule

// File: rtl/slog_slot_seq.sv
module slog_slot_seq
  import slog_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int SAMPLE_WORDS = 32,
  parameter int CNT_W        = 24,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W = $clog2(SAMPLE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  start_ch,
  output logic             active,
  output logic [CH_W-1:0]  cur_ch,
  output logic [IDX_W-1:0] slot,
  output logic [CNT_W-1:0] count
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SAMPLE_WORDS - 1);

  seq_state_e       state_q;
  logic [CH_W-1:0]  cur_q;
  logic [IDX_W-1:0] slot_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cur_q   <= '0;
      slot_q  <= '0;
      count_q <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            cur_q   <= start_ch;
            slot_q  <= '0;
          end
        end
        SEQ_RUN: begin
          if (slot_q == LAST_SLOT) begin
            state_q <= SEQ_IDLE;
            count_q <= count_q + CNT_W'(1);
          end else begin
            slot_q <= slot_q + IDX_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign active = (state_q == SEQ_RUN);
  assign cur_ch = cur_q;
  assign slot   = slot_q;
  assign count  = count_q;

  // R5: the served channel does not change within a sample
  assert_chan_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && $past(state_q == SEQ_RUN)) |-> $stable(cur_q));

  // R10: the counter holds or steps by exactly one
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1)));
endmodule

// File: rtl/sample_log_arbiter.sv
module sample_log_arbiter
  import slog_pkg::*;
#(
  parameter int NUM_CH       = DEF_NUM_CH,
  parameter int WORD_W       = DEF_WORD_W,
  parameter int TS_WORDS     = DEF_TS_WORDS,
  parameter int SAMPLE_WORDS = DEF_SAMPLE_WORDS,
  parameter int CNT_W        = DEF_CNT_W,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TS_SEL_W = (TS_WORDS > 1) ? $clog2(TS_WORDS) : 1,
  localparam int IDX_W    = $clog2(SAMPLE_WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ts_req_pulse,
  input  logic [NUM_CH-1:0]        ts_grant,
  output logic [NUM_CH-1:0]        ts_req_hold,
  input  logic [NUM_CH-1:0]        chan_ready,
  input  logic [NUM_CH*WORD_W-1:0] chan_data,
  output logic [NUM_CH-1:0]        chan_next,
  input  logic [WORD_W-1:0]        ts_data,
  output logic [CH_W-1:0]          sel_chan,
  output logic [TS_SEL_W-1:0]      ts_word_sel,
  output logic                     ts_select,
  output logic [WORD_W-1:0]        log_word,
  output logic                     word_valid,
  output logic [CNT_W-1:0]         sample_count
);
  logic [NUM_CH-1:0] stamped;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] pick;
  logic [NUM_CH-1:0] consume;
  logic              pick_any;
  logic [CH_W-1:0]   pick_idx;
  logic              take;
  logic              active;
  logic [CH_W-1:0]   cur;
  logic [IDX_W-1:0]  slot;
  logic              ts_slot;
  logic              data_slot;

  slog_req_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_pulse (ts_req_pulse),
    .grant     (ts_grant),
    .consume   (consume),
    .hold_o    (ts_req_hold),
    .stamped_o (stamped)
  );

  assign elig    = stamped & chan_ready;
  assign take    = !active && pick_any;
  assign consume = take ? pick : '0;

  slog_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .take     (take),
    .pick     (pick),
    .pick_any (pick_any),
    .pick_idx (pick_idx)
  );

  slog_slot_seq #(
    .NUM_CH       (NUM_CH),
    .SAMPLE_WORDS (SAMPLE_WORDS),
    .CNT_W        (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .start_ch (pick_idx),
    .active   (active),
    .cur_ch   (cur),
    .slot     (slot),
    .count    (sample_count)
  );

  assign ts_slot     = active && (slot < IDX_W'(TS_WORDS));
  assign data_slot   = active && !ts_slot;
  assign sel_chan    = cur;
  assign ts_word_sel = ts_slot ? slot[TS_SEL_W-1:0] : '0;
  assign chan_next   = (data_slot && chan_ready[cur]) ? (NUM_CH'(1) << cur) : '0;

  // first mux stage: channel data and ready, slot kind, slot valid
  logic [WORD_W-1:0] s1_data;
  logic              s1_rdy;
  logic              s1_ts;
  logic              s1_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_data <= '0;
      s1_rdy  <= 1'b0;
      s1_ts   <= 1'b0;
      s1_vld  <= 1'b0;
    end else begin
      s1_data <= chan_data[cur*WORD_W +: WORD_W];
      s1_rdy  <= chan_ready[cur];
      s1_ts   <= ts_slot;
      s1_vld  <= active;
    end
  end

  assign ts_select = s1_ts;

  // second mux stage: timestamp, data or zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_word   <= '0;
      word_valid <= 1'b0;
    end else begin
      log_word   <= s1_ts ? ts_data : (s1_rdy ? s1_data : '0);
      word_valid <= s1_vld;
    end
  end

  // R6: one channel advanced at a time
  assert_next_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_next));

  // R6 / R7: a next strobe never falls in a timestamp slot
  assert_next_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_next) |=> !ts_select);

  // R8: a timestamp word is followed by a valid output
  assert_ts_then_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ts_select |=> word_valid);

  // R9: a data slot with the channel not ready produces a zero word
  assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_ts && !s1_rdy) |=> (log_word == '0));
endmodule

// File: tb/sample_log_arbiter_bench.sv
module sample_log_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ts_req_pulse = '0;
  logic [3:0]  ts_grant = '0;
  logic [3:0]  chan_ready = '0;
  logic [63:0] chan_data = '0;
  logic [15:0] ts_data = '0;
  logic [3:0]  ts_req_hold;
  logic [3:0]  chan_next;
  logic [1:0]  sel_chan;
  logic [1:0]  ts_word_sel;
  logic        ts_select;
  logic [15:0] log_word;
  logic        word_valid;
  logic [23:0] sample_count;

  always #4 clk = ~clk;

  sample_log_arbiter u_sample_log_arbiter (
    .clk(clk), .rst_n(rst_n), .ts_req_pulse(ts_req_pulse), .ts_grant(ts_grant),
    .ts_req_hold(ts_req_hold), .chan_ready(chan_ready), .chan_data(chan_data),
    .chan_next(chan_next), .ts_data(ts_data), .sel_chan(sel_chan),
    .ts_word_sel(ts_word_sel), .ts_select(ts_select), .log_word(log_word),
    .word_valid(word_valid), .sample_count(sample_count)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // cycle model of the requirements
  logic [3:0]  m_hold, m_stamp;
  bit          m_act;
  int          m_cur, m_idx, m_last, m_cnt;
  bit          m1_ts, m1_rdy, m1_vld, m_valid;
  logic [15:0] m1_dat, m_log;
  int          pend_ch, pend_sel;
  int          order[$];
  int          valid_seen;

  function automatic logic [15:0] ts_val(int ch, int sel);
    return {4'hA, 2'(ch), 2'(sel), 8'h5C};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hold = '0; m_stamp = '0; m_act = 0; m_cur = 0; m_idx = 0; m_last = 3; m_cnt = 0;
    m1_ts = 0; m1_rdy = 0; m1_vld = 0; m_valid = 0; m1_dat = '0; m_log = '0;
    pend_ch = 0; pend_sel = 0;
  endtask

  task automatic compare();
    logic [3:0] exp_next;
    exp_next = (m_act && m_idx >= 4 && chan_ready[m_cur]) ? (4'b1 << m_cur) : 4'b0;
    chk(chan_next == exp_next, "R6 chan_next", chan_next, exp_next);
    chk(ts_req_hold == m_hold, "R2 ts_req_hold", ts_req_hold, m_hold);
    chk(ts_select == m1_ts, "R7 ts_select", ts_select, m1_ts);
    chk(word_valid == m_valid, "R8 word_valid", word_valid, m_valid);
    chk(sample_count == 24'(m_cnt), "R10 sample_count", sample_count, m_cnt);
    if (m_act) begin
      chk(sel_chan == 2'(m_cur), m_idx == 0 ? "R4 sel_chan start" : "R5 sel_chan",
          sel_chan, m_cur);
      chk(ts_word_sel == 2'(m_idx < 4 ? m_idx : 0), "R5 ts_word_sel", ts_word_sel,
          m_idx < 4 ? m_idx : 0);
      if (m_idx == 0) order.push_back(int'(sel_chan));
    end
    if (m_valid) begin
      chk(log_word == m_log, "R9 log_word", log_word, m_log);
      valid_seen++;
    end
  endtask

  task automatic step(logic [3:0] p, logic [3:0] g);
    logic [3:0] elig, pickm;
    int pk;
    bit found;
    logic [15:0] nlog;
    bit nvalid;
    elig = m_stamp & chan_ready;
    pickm = '0; pk = m_last; found = 0;
    for (int k = 1; k <= 4; k++) begin
      int c;
      c = (m_last + k) % 4;
      if (!found && elig[c]) begin found = 1; pk = c; end
    end
    if (!m_act && found) pickm = 4'b1 << pk;
    nlog = m1_ts ? ts_data : (m1_rdy ? m1_dat : 16'h0);
    nvalid = m1_vld;
    m1_ts = m_act && m_idx < 4;
    m1_rdy = chan_ready[m_cur];
    m1_dat = chan_data[m_cur*16 +: 16];
    m1_vld = m_act;
    m_log = nlog; m_valid = nvalid;
    m_stamp = (m_stamp & ~pickm) | (g & m_hold);
    m_hold = (m_hold & ~g) | p;
    if (!m_act) begin
      if (found) begin m_act = 1; m_cur = pk; m_idx = 0; m_last = pk; end
    end else if (m_idx == 31) begin
      m_act = 0; m_cnt++;
    end else m_idx++;
  endtask

  // one cycle: check at the falling edge, drive new inputs, advance the model
  task automatic tick(logic [3:0] p, logic [3:0] g, logic [3:0] r);
    int cur_sel;
    compare();
    cur_sel = (m_act && m_idx < 4) ? m_idx : 0;
    ts_req_pulse = p;
    ts_grant = g;
    chan_ready = r;
    for (int i = 0; i < 4; i++) chan_data[i*16 +: 16] = 16'($urandom) | 16'h0001;
    ts_data = ts_val(pend_ch, pend_sel);
    pend_ch = m_cur; pend_sel = cur_sel;
    step(p, g);
    @(negedge clk);
  endtask

  initial begin
    int c0;
    logic [3:0] rdy;
    void'($urandom(32'd20240607));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(ts_req_hold == 0, "R1 hold after reset", ts_req_hold, 0);
    chk(chan_next == 0, "R1 next after reset", chan_next, 0);
    chk(word_valid == 0 && ts_select == 0, "R1 valid/select after reset",
        {word_valid, ts_select}, 0);
    chk(sample_count == 0, "R1 count after reset", sample_count, 0);
    rst_n = 1'b1;

    // all four request, then all granted: service order 0,1,2,3 (R4)
    tick(4'hF, 4'h0, 4'hF);
    tick(4'h0, 4'hF, 4'hF);
    order.delete();
    repeat (140) tick(4'h0, 4'h0, 4'hF);
    chk(order.size() == 4, "R4 sample count in burst", order.size(), 4);
    if (order.size() == 4)
      chk(order[0] == 0 && order[1] == 1 && order[2] == 2 && order[3] == 3,
          "R4 order", {order[0], order[1], order[2], order[3]}, 32'h00010203);
    chk(sample_count == 4, "R10 count after burst", sample_count, 4);

    // ready drops mid-sample on channel 1: zero fill (R9) and strobe stop (R6)
    tick(4'h2, 4'h0, 4'h2);
    tick(4'h0, 4'h2, 4'h2);
    repeat (12) tick(4'h0, 4'h0, 4'h2);
    repeat (30) tick(4'h0, 4'h0, 4'h0);
    chk(sample_count == 5, "R9 padded sample completes", sample_count, 5);

    // grant with no held request is ignored (R3)
    c0 = int'(sample_count);
    valid_seen = 0;
    repeat (40) tick(4'h0, 4'h4, 4'hF);
    chk(int'(sample_count) == c0, "R3 unrequested grant count", sample_count, c0);
    chk(valid_seen == 0, "R3 unrequested grant output", valid_seen, 0);

    // constrained random traffic
    rdy = 4'h0;
    for (int n = 0; n < 6000; n++) begin
      logic [3:0] p, g;
      for (int i = 0; i < 4; i++) begin
        if ($urandom_range(19) == 0) rdy[i] = ~rdy[i];
        p[i] = ($urandom_range(15) == 0);
        g[i] = ($urandom_range(3) == 0);
      end
      tick(p, g, rdy);
    end
    chk(sample_count > 24'd5, "R10 random traffic produced samples", sample_count, 6);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule